// File: doc/BRIEF.md
# Peak-Current-Mode PWM Gate Sequencer

This block drives the two power switches of a synchronous step-down converter in fixed-frequency operation. It works in the system clock domain. A one-clock `cyc_tick` pulse marks each switching-cycle boundary. The analog loop reports to it only through digital flags: the PWM comparator trip, the overcurrent trip and the short-circuit detect. The block converts these into a high-side gate command and a low-side gate command. It applies a minimum high-side on-time, break-before-make gaps and full duty cycle when the comparator stays quiet.

The sequencer is a five-state machine:
- `IDLE`: both switches off.
- `GAP_HI`: dead time before the high side turns on.
- `HIGH`: high side on.
- `GAP_LO`: dead time before the low side turns on.
- `LOW`: low side on.

The transitions are:
- `IDLE` to `GAP_HI` on a cycle start.
- `GAP_HI` to `HIGH` when the gap expires.
- `HIGH` to `GAP_LO` on an overcurrent, or on a PWM trip once the minimum on-time has elapsed.
- `GAP_LO` to `LOW` when the gap expires.
- `GAP_LO` or `LOW` to `GAP_HI` on a cycle start.
- Any state to `IDLE` while enable is low.

While a short circuit is flagged, a divider lets only one boundary tick in `SHORT_DIV` start a cycle. The accepted boundaries appear on `cyc_strobe`.

Top module: `pwm_gate_seq`

## Requirements
- R1: While `rst_n` is low, and in the clock after any clock edge sampled with `en` low, both `hs_on` and `ls_on` are 0.
- R2: A cycle start seen in `IDLE`, `GAP_LO` or `LOW` turns both gates off for exactly `DEAD_CLKS` clocks, after which `hs_on` rises.
- R3: A PWM trip sampled in `HIGH`, once the high side has been on for at least `MIN_ON_CLKS` clocks, drops `hs_on` at the next edge and raises `ls_on` `DEAD_CLKS` clocks later.
- R4: `ls_on` stays 1 until a cycle start is strobed or enable goes low; PWM trips have no effect on it.
- R5: An overcurrent flag sampled while `hs_on` is 1 drops `hs_on` at the next edge, even before the minimum on-time.
- R6: PWM trips that arrive before the high side has been on for `MIN_ON_CLKS` clocks are ignored; the high side then stays on.
- R7: If no trip arrives, `hs_on` stays 1 across cycle boundaries, which gives 100% duty cycle.
- R8: With `short_det` low, `cyc_strobe` equals `cyc_tick`. With `short_det` high, only the first tick and then every `SHORT_DIV`-th tick (default 8) produce `cyc_strobe`, counted from the assertion of `short_det`.
- R9: Dropping `en` aborts a cycle at any point. After `en` returns, nothing switches until the next strobed start, and the R2 gap is applied again.
- R10: `hs_on` and `ls_on` are never 1 in the same clock, and every turn-on of either gate follows at least `DEAD_CLKS` clocks with both gates off.
- R11: A cycle start that arrives during the `GAP_LO` gap is honoured: the low side never turns on, and the gap before the high side restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low forces both gates off |
| cyc_tick | input | 1 | One-clock pulse at each switching-cycle boundary |
| pwm_trip | input | 1 | PWM comparator trip (sensed current reached control level) |
| ocp_trip | input | 1 | Overcurrent comparator trip |
| short_det | input | 1 | Output short-circuit detected |
| hs_on | output | 1 | High-side switch command |
| ls_on | output | 1 | Low-side switch command |
| cyc_strobe | output | 1 | Accepted cycle start after short-circuit division |

## Verification
Two collisions need care in this design:
- An overcurrent trip and the minimum on-time window can fall in the same clock. The bench raises `ocp_trip` one clock into `HIGH` and expects the high side to drop at the next edge, while a PWM trip held across the same window is expected to be ignored.
- A cycle start can land inside the low-side dead gap. With a switching period of 8 clocks and a late trip, the tick arrives during `GAP_LO`, and the bench expects `ls_on` never to rise before the next high-side gap.

A behavioural model in the bench predicts both gates and the strobe on every clock. A random phase then mixes all flags, including short-circuit division and enable drops.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_GAP_HI = 3'd1,
        PH_HIGH   = 3'd2,
        PH_GAP_LO = 3'd3,
        PH_LOW    = 3'd4
    } phase_e;

endpackage

// File: rtl/pwm_cycle_div.sv
module pwm_cycle_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic slow,
    output logic start
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

    logic [CW-1:0] tick_cnt;

    generate
        if (POW2) begin : g_wrap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tick_cnt <= '0;
                end else if (!slow) begin
                    tick_cnt <= '0;
                end else if (tick) begin
                    tick_cnt <= tick_cnt + CW'(1);
                end
            end
        end else begin : g_cmp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tick_cnt <= '0;
                end else if (!slow) begin
                    tick_cnt <= '0;
                end else if (tick) begin
                    tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + CW'(1);
                end
            end
        end
    endgenerate

    // A boundary is accepted at full rate, or only when the divider sits at zero.
    assign start = tick && (!slow || (tick_cnt == '0));

endmodule

// File: rtl/pwm_hold_cnt.sv
module pwm_hold_cnt #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (clr) begin
            age <= '0;
        end else if (age != LAST) begin
            age <= age + W'(1);
        end
    end

    // High during the LIMIT-th clock (and later) spent in the current phase.
    assign expired = (age == LAST);

endmodule

// File: rtl/pwm_gate_fsm.sv
module pwm_gate_fsm
    import pwm_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic pwm_trip,
    input  logic ocp_trip,
    input  logic gap_done,
    input  logic ton_done,
    output logic phase_moved,
    output logic hs_on,
    output logic ls_on
);
    phase_e state_q;
    phase_e state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transition logic
    always_comb begin
        state_nxt = state_q;
        if (!en) begin
            state_nxt = PH_IDLE;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (start) state_nxt = PH_GAP_HI;
                end
                PH_GAP_HI: begin
                    if (gap_done) state_nxt = PH_HIGH;
                end
                PH_HIGH: begin
                    if (ocp_trip) begin
                        state_nxt = PH_GAP_LO;
                    end else if (pwm_trip && ton_done) begin
                        state_nxt = PH_GAP_LO;
                    end
                end
                PH_GAP_LO: begin
                    if (start) begin
                        state_nxt = PH_GAP_HI;
                    end else if (gap_done) begin
                        state_nxt = PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (start) state_nxt = PH_GAP_HI;
                end
                default: state_nxt = PH_IDLE;
            endcase
        end
    end

    assign phase_moved = (state_nxt != state_q);

    // Output register: gate commands come straight from flops, one per gate.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_on <= 1'b0;
            ls_on <= 1'b0;
        end else begin
            hs_on <= (state_nxt == PH_HIGH);
            ls_on <= (state_nxt == PH_LOW);
        end
    end

endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq #(
    parameter int DEAD_CLKS   = 2,
    parameter int MIN_ON_CLKS = 4,
    parameter int SHORT_DIV   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_tick,
    input  logic pwm_trip,
    input  logic ocp_trip,
    input  logic short_det,
    output logic hs_on,
    output logic ls_on,
    output logic cyc_strobe
);
    logic start;
    logic phase_moved;
    logic gap_done;
    logic ton_done;

    pwm_cycle_div #(.DIV(SHORT_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cyc_tick),
        .slow  (short_det),
        .start (start)
    );

    pwm_hold_cnt #(.LIMIT(DEAD_CLKS)) u_gap_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (phase_moved),
        .expired (gap_done)
    );

    pwm_hold_cnt #(.LIMIT(MIN_ON_CLKS)) u_ton_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (phase_moved),
        .expired (ton_done)
    );

    pwm_gate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .start       (start),
        .pwm_trip    (pwm_trip),
        .ocp_trip    (ocp_trip),
        .gap_done    (gap_done),
        .ton_done    (ton_done),
        .phase_moved (phase_moved),
        .hs_on       (hs_on),
        .ls_on       (ls_on)
    );

    assign cyc_strobe = start;

endmodule

// File: rtl/pwm_gate_seq_chk.sv
module pwm_gate_seq_chk #(
    parameter int DEAD_CLKS   = 2,
    parameter int MIN_ON_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cyc_tick,
    input logic ocp_trip,
    input logic short_det,
    input logic hs_on,
    input logic ls_on,
    input logic cyc_strobe
);
    logic [7:0] off_run;
    logic [7:0] on_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run <= '0;
            on_run  <= '0;
        end else begin
            if (hs_on || ls_on) off_run <= '0;
            else if (off_run != 8'hFF) off_run <= off_run + 8'd1;
            if (!hs_on) on_run <= '0;
            else if (on_run != 8'hFF) on_run <= on_run + 8'd1;
        end
    end

    a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_on && !ls_on));

    a_r10_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    a_r10_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> (int'(off_run) >= DEAD_CLKS));

    a_r10_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> (int'(off_run) >= DEAD_CLKS));

    a_r5_ocp_cuts_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on && ocp_trip && en) |=> !hs_on);

    a_r6_min_on_respected: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hs_on) && $past(en) && !$past(ocp_trip)) |-> (int'(on_run) >= MIN_ON_CLKS));

    a_r4_ls_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on && en && !cyc_strobe) |=> ls_on);

    a_r8_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strobe |-> cyc_tick);

    a_r8_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        !short_det |-> (cyc_strobe == cyc_tick));

endmodule

bind pwm_gate_seq pwm_gate_seq_chk #(
    .DEAD_CLKS   (DEAD_CLKS),
    .MIN_ON_CLKS (MIN_ON_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cyc_tick   (cyc_tick),
    .ocp_trip   (ocp_trip),
    .short_det  (short_det),
    .hs_on      (hs_on),
    .ls_on      (ls_on),
    .cyc_strobe (cyc_strobe)
);

// File: tb/test_pwm_gate_seq.sv
`timescale 1ns/1ps
module test_pwm_gate_seq;
    localparam int DEAD  = 2;
    localparam int MINON = 4;
    localparam int SDIV  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic cyc_tick = 1'b0;
    logic pwm_trip = 1'b0;
    logic ocp_trip = 1'b0;
    logic short_det = 1'b0;
    logic hs_on, ls_on, cyc_strobe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur = "R1";

    // model state: 0 off, 1 gap before high, 2 high, 3 gap before low, 4 low
    int m_phase = 0;
    int m_time = 0;
    int m_scnt = 0;
    int m_nxt;
    bit m_go;

    always #2 clk = ~clk;

    pwm_gate_seq #(.DEAD_CLKS(DEAD), .MIN_ON_CLKS(MINON), .SHORT_DIV(SDIV)) i_pwm_gate_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .cyc_tick(cyc_tick), .pwm_trip(pwm_trip),
        .ocp_trip(ocp_trip), .short_det(short_det), .hs_on(hs_on), .ls_on(ls_on),
        .cyc_strobe(cyc_strobe)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_time = 0; m_scnt = 0;
        end else begin
            m_go = cyc_tick && (!short_det || m_scnt == 0);
            if (!short_det) m_scnt = 0;
            else if (cyc_tick) m_scnt = (m_scnt + 1) % SDIV;
            m_nxt = m_phase;
            if (!en) m_nxt = 0;
            else begin
                case (m_phase)
                    0: if (m_go) m_nxt = 1;
                    1: if (m_time + 1 >= DEAD) m_nxt = 2;
                    2: if (ocp_trip || (pwm_trip && m_time + 1 >= MINON)) m_nxt = 3;
                    3: if (m_go) m_nxt = 1; else if (m_time + 1 >= DEAD) m_nxt = 4;
                    4: if (m_go) m_nxt = 1;
                    default: m_nxt = 0;
                endcase
            end
            m_time = (m_nxt == m_phase) ? m_time + 1 : 0;
            m_phase = m_nxt;
        end
    end

    task automatic check_bit(input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit e, input bit t, input bit p, input bit o, input bit s);
        @(negedge clk);
        check_bit("hs_on", hs_on, m_phase == 2);
        check_bit("ls_on", ls_on, m_phase == 4);
        en = e; cyc_tick = t; pwm_trip = p; ocp_trip = o; short_det = s;
        #1;
        check_bit("cyc_strobe", cyc_strobe, t && (!s || m_scnt == 0));
    endtask

    // Periodic pattern: phase counter ph runs 0..per-1, tick at ph 0.
    task automatic run_pat(input string lbl, input int n, input int per,
                           input int trip_lo, input int trip_hi, input int ocp_at,
                           input bit s, input int off_at);
        cur = lbl;
        for (int i = 0; i < n; i++) begin
            int ph;
            ph = i % per;
            step(!(ph == off_at), ph == 0, (ph >= trip_lo) && (ph <= trip_hi), ph == ocp_at, s);
        end
    endtask

    initial begin
        cur = "R1 reset";
        repeat (4) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        cur = "R1 disabled";
        repeat (4) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        // high on at ph3; trip honoured from ph6 with MIN_ON of 4
        run_pat("R2 R3 R4 normal", 60, 12, 6, 6, -1, 1'b0, -1);
        run_pat("R6 early trip ignored", 48, 12, 3, 4, -1, 1'b0, -1);
        run_pat("R6 R3 held trip", 48, 12, 3, 8, -1, 1'b0, -1);
        run_pat("R5 ocp before min on", 48, 12, 3, 9, 4, 1'b0, -1);
        run_pat("R7 full duty", 40, 10, -1, -1, -1, 1'b0, -1);
        run_pat("R11 start in low gap", 48, 8, 6, 6, -1, 1'b0, -1);
        run_pat("R8 short divides", 120, 3, 1, 1, -1, 1'b1, -1);
        run_pat("R8 full rate again", 30, 3, 1, 1, -1, 1'b0, -1);
        run_pat("R9 abort in high", 48, 12, 8, 8, -1, 1'b0, 5);
        run_pat("R9 abort in low", 48, 12, 6, 6, -1, 1'b0, 10);
        cur = "R10 random";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 40) != 0, ($urandom % 6) == 0, ($urandom % 4) == 0,
                 ($urandom % 25) == 0, ((i / 300) % 2) == 1);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule